// File: doc/BRIEF.md
# Variable-Length Instruction Prefetch Queue

This block is the fetch stage of a stack-machine bytecode core. It keeps a small byte queue filled with the next bytes of the instruction stream. It presents the oldest byte, which is always an opcode, together with the two bytes behind it on a three-byte window. The decoder sees the whole of the current instruction at once, whether it has no immediate bytes, one, or two.

Each cycle the decoder returns the length of the instruction it has just taken (1 to 3 bytes, or 0 when it takes nothing). The queue shifts by exactly that many bytes, so the next opcode moves into the head slot. At the tail, the queue appends one four-byte memory word whenever enough slots will be free. When a branch resolves as taken, a flush empties the queue and loads the fetch address from the redirect input. Fetching then restarts at the branch target.

Top module: `instr_prefetch_q`

## Requirements
- R1: After reset the queue is empty: `level` is 0, `win_valid` is 0 and `fetch_addr` equals the RESET_ADDR parameter (default 0).
- R2: `win_data` bits [8k+7:8k] hold the k-th oldest queued byte, with the head opcode in bits [7:0]. `win_valid[k]` is 1 exactly when `level` > k, so the valid bits always form a run starting at bit 0.
- R3: `fetch_req` is high exactly when `flush` is low and the number of free slots left after this cycle's shift is at least 4.
- R4: In a cycle with `fetch_req` and `mem_valid` both high, the four bytes of `mem_data` are appended behind the bytes that remain, in this order: bits [7:0] (the byte at `fetch_addr`) first, then bits [15:8], [23:16] and [31:24]. `fetch_addr` then advances by 4.
- R5: A `dec_len` of 1, 2 or 3 that does not exceed `level` removes exactly that many bytes from the head on the next clock edge. The following byte becomes the new head.
- R6: A `dec_len` larger than `level` raises `dec_stall` in the same cycle, and the queue does not shift. A `dec_len` of 0 also leaves the queue unshifted and keeps `dec_stall` low.
- R7: While `flush` is high, `fetch_req` is low. On the next edge `level` becomes 0 and `fetch_addr` takes the value of `redirect_addr`. Any `dec_len` or memory data presented in that cycle is discarded.
- R8: `level` reports the number of valid bytes and never exceeds the queue depth of 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Taken-branch flush |
| redirect_addr | input | 16 | Branch target byte address |
| dec_len | input | 2 | Length of the instruction consumed this cycle, 0 for none |
| dec_stall | output | 1 | Requested length exceeds the valid bytes |
| win_data | output | 24 | Head byte and the two bytes behind it |
| win_valid | output | 3 | One valid bit per window byte |
| level | output | 4 | Count of valid queued bytes |
| fetch_req | output | 1 | Request for one memory word |
| fetch_addr | output | 16 | Byte address of the requested word |
| mem_valid | input | 1 | Memory word on mem_data is valid this cycle |
| mem_data | input | 32 | Memory word, lowest byte at fetch_addr |

## Verification
The bound checker watches every cycle for the following:
- the queue level staying within its depth;
- the window valid bits staying contiguous;
- the level changing by exactly the consumed length plus four on a refill;
- a stall holding both the level and the head byte;
- a flush emptying the queue and loading the target address;
- the fetch address stepping by four on each accepted word.

Only the directed scenarios can show that the bytes reach the head in stream order across mixed lengths. They also show where the request threshold lies around five and six occupied slots, and that a refill combines correctly with a shift in the same cycle. Finally, they show that memory data offered during a flush never enters the queue.

// File: rtl/instr_prefetch_q.sv
module instr_prefetch_q #(
  parameter int DEPTH      = 9,
  parameter int WORD_BYTES = 4,
  parameter int WIN        = 3,
  parameter int ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0,
  localparam int LVL_W = $clog2(DEPTH + 1),
  localparam int LEN_W = $clog2(WIN + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    flush,
  input  logic [ADDR_W-1:0]       redirect_addr,
  input  logic [LEN_W-1:0]        dec_len,
  output logic                    dec_stall,
  output logic [8*WIN-1:0]        win_data,
  output logic [WIN-1:0]          win_valid,
  output logic [LVL_W-1:0]        level,
  output logic                    fetch_req,
  output logic [ADDR_W-1:0]       fetch_addr,
  input  logic                    mem_valid,
  input  logic [8*WORD_BYTES-1:0] mem_data
);

  logic [7:0]       q  [DEPTH];
  logic [7:0]       nq [DEPTH];
  logic [LVL_W-1:0] cnt;
  logic [LVL_W-1:0] len_x;
  logic [LVL_W-1:0] shift;
  logic [LVL_W-1:0] remain;
  logic [LVL_W-1:0] free_slots;
  logic             wr;

  assign len_x      = {{(LVL_W-LEN_W){1'b0}}, dec_len};
  assign dec_stall  = len_x > cnt;
  assign shift      = (flush || dec_stall) ? '0 : len_x;
  assign remain     = cnt - shift;
  assign free_slots = LVL_W'(DEPTH) - remain;
  assign fetch_req  = !flush && (free_slots >= LVL_W'(WORD_BYTES));
  assign wr         = fetch_req && mem_valid;
  assign level      = cnt;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      nq[i] = 8'h00;
      for (int k = 0; k <= WIN; k++)
        if (shift == LVL_W'(k) && i + k < DEPTH)
          nq[i] = q[(i + k) % DEPTH];
      for (int b = 0; b < WORD_BYTES; b++)
        if (wr && ({1'b0, remain} + (LVL_W+1)'(b) == (LVL_W+1)'(i)))
          nq[i] = mem_data[8*b +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt        <= '0;
      fetch_addr <= RESET_ADDR;
      for (int i = 0; i < DEPTH; i++) q[i] <= 8'h00;
    end else if (flush) begin
      cnt        <= '0;
      fetch_addr <= redirect_addr;
    end else begin
      cnt <= remain + (wr ? LVL_W'(WORD_BYTES) : '0);
      if (wr) fetch_addr <= fetch_addr + ADDR_W'(WORD_BYTES);
      for (int i = 0; i < DEPTH; i++) q[i] <= nq[i];
    end
  end

  for (genvar k = 0; k < WIN; k++) begin : g_win
    assign win_data[8*k +: 8] = q[k];
    assign win_valid[k]       = cnt > LVL_W'(k);
  end

endmodule

// File: rtl/prefetch_q_chk.sv
module prefetch_q_chk #(
  parameter int DEPTH      = 9,
  parameter int WORD_BYTES = 4,
  parameter int WIN        = 3,
  parameter int ADDR_W     = 16,
  parameter int LVL_W      = 4,
  parameter int LEN_W      = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flush,
  input logic [ADDR_W-1:0] redirect_addr,
  input logic [LEN_W-1:0]  dec_len,
  input logic              dec_stall,
  input logic [8*WIN-1:0]  win_data,
  input logic [WIN-1:0]    win_valid,
  input logic [LVL_W-1:0]  level,
  input logic              fetch_req,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic              mem_valid
);

  assert_level_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    int'(level) <= DEPTH);

  assert_window_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (win_valid & (win_valid + WIN'(1))) == '0);

  assert_advance_exact_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_len != '0 && !dec_stall && !flush) |=>
      int'(level) == int'($past(level)) - int'($past(dec_len))
                     + ($past(fetch_req && mem_valid) ? WORD_BYTES : 0));

  assert_stall_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_stall && !flush) |=>
      int'(level) == int'($past(level)) + ($past(fetch_req && mem_valid) ? WORD_BYTES : 0));

  assert_stall_head_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_stall && !flush && level != '0) |=> $stable(win_data[7:0]));

  assert_flush_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (level == '0 && win_valid == '0 && fetch_addr == $past(redirect_addr)));

  assert_no_req_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !fetch_req);

  assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && mem_valid && !flush) |=> fetch_addr == $past(fetch_addr) + ADDR_W'(WORD_BYTES));

endmodule

bind instr_prefetch_q prefetch_q_chk #(
  .DEPTH(DEPTH), .WORD_BYTES(WORD_BYTES), .WIN(WIN), .ADDR_W(ADDR_W),
  .LVL_W(LVL_W), .LEN_W(LEN_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .redirect_addr(redirect_addr),
  .dec_len(dec_len), .dec_stall(dec_stall), .win_data(win_data),
  .win_valid(win_valid), .level(level), .fetch_req(fetch_req),
  .fetch_addr(fetch_addr), .mem_valid(mem_valid)
);

// File: tb/instr_prefetch_q_tb.sv
`timescale 1ns/1ps
module instr_prefetch_q_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic [15:0] redirect_addr = '0;
  logic [1:0]  dec_len = '0;
  logic        dec_stall;
  logic [23:0] win_data;
  logic [2:0]  win_valid;
  logic [3:0]  level;
  logic        fetch_req;
  logic [15:0] fetch_addr;
  logic        mem_valid = 1'b0;
  logic [31:0] mem_data;

  int total = 0;
  int bad = 0;
  logic [15:0] head;
  bit done = 0;

  always #5 clk = ~clk;

  function automatic logic [7:0] f(input logic [15:0] a);
    return a[7:0] * 8'd13 + 8'd7;
  endfunction

  assign mem_data = {f(fetch_addr + 16'd3), f(fetch_addr + 16'd2),
                     f(fetch_addr + 16'd1), f(fetch_addr)};

  instr_prefetch_q u_dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .redirect_addr(redirect_addr),
    .dec_len(dec_len), .dec_stall(dec_stall), .win_data(win_data),
    .win_valid(win_valid), .level(level), .fetch_req(fetch_req),
    .fetch_addr(fetch_addr), .mem_valid(mem_valid), .mem_data(mem_data)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk_window(input string req);
    for (int k = 0; k < 3; k++)
      if (int'(level) > k) chk(req, int'(win_data[8*k +: 8]), int'(f(head + 16'(k))));
  endtask

  task automatic do_flush(input logic [15:0] tgt);
    flush = 1'b1; redirect_addr = tgt;
    tick;
    flush = 1'b0; head = tgt;
  endtask

  task automatic t_reset;
    mem_valid = 1'b0;
    repeat (2) tick;
    rst_n = 1'b1;
    tick;
    chk("R1 level", int'(level), 0);
    chk("R1 win_valid", int'(win_valid), 0);
    chk("R1 fetch_addr", int'(fetch_addr), 0);
    chk("R3 empty requests", int'(fetch_req), 1);
    head = 16'h0000;
  endtask

  task automatic t_fill;
    mem_valid = 1'b1;
    tick;
    chk("R4 first word level", int'(level), 4);
    chk("R4 addr step", int'(fetch_addr), 4);
    tick;
    chk("R4 second word level", int'(level), 8);
    chk("R3 no request with one free", int'(fetch_req), 0);
    chk("R2 all valid", int'(win_valid), 7);
    chk_window("R2 window after fill");
  endtask

  task automatic t_consume;
    int lens[7] = '{1, 2, 3, 3, 2, 1, 3};
    int lvl;
    mem_valid = 1'b1;
    for (int n = 0; n < 7; n++) begin
      lvl = int'(level);
      dec_len = 2'(lens[n]);
      #1;
      chk("R3 request rule", int'(fetch_req), ((9 - (lvl - lens[n])) >= 4) ? 1 : 0);
      tick;
      head = head + 16'(lens[n]);
      lvl = lvl - lens[n] + (((9 - (lvl - lens[n])) >= 4) ? 4 : 0);
      chk("R5 level after consume", int'(level), lvl);
      chk_window("R5 next opcode at head");
    end
    dec_len = 2'd0;
  endtask

  task automatic t_stall;
    mem_valid = 1'b0;
    do_flush(16'h0100);
    mem_valid = 1'b1;
    tick;
    mem_valid = 1'b0;
    dec_len = 2'd3;
    tick;
    head = head + 16'd3;
    chk("R5 level 1", int'(level), 1);
    dec_len = 2'd2;
    #1;
    chk("R6 stall raised", int'(dec_stall), 1);
    tick;
    chk("R6 level held", int'(level), 1);
    chk("R6 head held", int'(win_data[7:0]), int'(f(head)));
    chk("R2 partial valid", int'(win_valid), 1);
    dec_len = 2'd0;
    #1;
    chk("R6 zero length no stall", int'(dec_stall), 0);
    tick;
    chk("R6 zero length no shift", int'(level), 1);
  endtask

  task automatic t_flush;
    mem_valid = 1'b1;
    tick;
    flush = 1'b1; redirect_addr = 16'h02A0; dec_len = 2'd1;
    #1;
    chk("R7 no request in flush", int'(fetch_req), 0);
    tick;
    flush = 1'b0; dec_len = 2'd0; head = 16'h02A0;
    chk("R7 emptied", int'(level), 0);
    chk("R7 valid cleared", int'(win_valid), 0);
    chk("R7 redirect", int'(fetch_addr), 16'h02A0);
    tick;
    chk("R4 refetch level", int'(level), 4);
    chk_window("R7 target bytes at head");
  endtask

  task automatic t_threshold;
    mem_valid = 1'b0;
    do_flush(16'h0300);
    mem_valid = 1'b1;
    tick; tick;
    mem_valid = 1'b0;
    chk("R4 level 8", int'(level), 8);
    dec_len = 2'd2;
    tick;
    head = head + 16'd2;
    dec_len = 2'd0;
    #1;
    chk("R3 six held gives no request", int'(fetch_req), 0);
    dec_len = 2'd1;
    #1;
    chk("R3 shift frees fourth slot", int'(fetch_req), 1);
    tick;
    head = head + 16'd1;
    dec_len = 2'd0;
    chk("R5 level 5", int'(level), 5);
    mem_valid = 1'b1;
    tick;
    chk("R8 full at depth", int'(level), 9);
    chk("R3 full no request", int'(fetch_req), 0);
    chk_window("R4 order kept at full");
    dec_len = 2'd3;
    tick;
    head = head + 16'd3;
    chk("R5 level 6 no refill", int'(level), 6);
    dec_len = 2'd2;
    tick;
    head = head + 16'd2;
    chk("R4 shift and refill", int'(level), 8);
    chk_window("R4 head after shift and refill");
    dec_len = 2'd3;
    tick; head = head + 16'd3;
    tick; head = head + 16'd3;
    dec_len = 2'd0;
    chk_window("R4 appended bytes reach head");
    mem_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset;
    t_fill;
    t_consume;
    t_stall;
    t_flush;
    t_threshold;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule